// File: doc/BRIEF.md
# Retired-Instruction Compare Timer

This block keeps a 64-bit counter that steps once for every instruction the core retires, along with a 32-bit compare value. When the lower half of the counter climbs up to the compare value, a level timer request is raised toward the trap logic. The request stays up until software writes the compare value again.

Software reaches the block through a small register port with a 2-bit selector. Selector 0 reads the lower count half and writes the whole 64-bit count. Selector 1 reads the upper count half and writes only that half. Selector 2 reads and writes the compare value. Selector 3 is unused. Reads are combinational. Writes take effect at the next clock edge.

The request flag is held by a two-state machine. `ST_ARMED` means no request is pending. `ST_FIRED` means the request is pending. The transition ARM_TO_FIRE (`ST_ARMED` to `ST_FIRED`) happens on a retire cycle that crosses the compare value. The transition FIRE_TO_ARM (`ST_FIRED` to `ST_ARMED`) happens on any compare write. Every other cycle holds the current state.

Top module: `retire_cmp_timer`

## Requirements
- R1: After reset, the count is 0, the compare value is 0 and `timer_pend_o` is low.
- R2: In a cycle with `retire_i` high and no count write, the count increases by exactly 1 at the next edge. In a cycle with no retire and no write, the count holds.
- R3: Reads are combinational. Selector 0 returns count[31:0] in bits 31:0, with bits 63:32 zero. Selector 1 returns count >> 32. Selector 2 returns the compare value, zero-extended.
- R4: A write with selector 0 replaces all 64 bits of the count with `csr_wdata_i`.
- R5: A write with selector 1 loads count[63:32] from `csr_wdata_i[31:0]` and leaves count[31:0] unchanged.
- R6: If a count write (selector 0 or 1) and `retire_i` occur in the same cycle, the written value is loaded, no increment is applied, and that retire cannot raise the request.
- R7: The request rises when a counted retire sees the old lower half L and compare C satisfying L <= C and L+1 >= C, compared unsigned at 33 bits. It is visible one cycle after that retire.
- R8: Once raised, the request stays high through later retires, including when the count moves past the compare value, until the compare value is written.
- R9: Any write with selector 2 loads the compare value from `csr_wdata_i[31:0]` and drops the request at the next edge. This holds even if a crossing happens in the same cycle.
- R10: When the lower half steps from all-ones to zero, the carry moves into the upper half. Counting then approaches the compare value again, so a later crossing raises the request anew. The step from all-ones with a compare value of all-ones is itself a crossing.
- R11: Writing the upper half does not change the request.
- R12: A write with selector 3 changes nothing, and a read with selector 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One pulse per retired instruction |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register selector: 0 lower count / full count, 1 upper count, 2 compare, 3 unused |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data for the selected register |
| timer_pend_o | output | 1 | Level timer request |

## Verification
The hardest situation to reach from the ports is the carry out of the lower half. Counting there one retire at a time would take billions of cycles. The stimulus instead writes the full count to a value just below all-ones and then retires a few times. It does this first with a low compare value, to show the carry alone raises nothing. It does it again with an all-ones compare value, where the wrapping step itself must raise the request. Same-cycle collisions are also driven on purpose: count write with retire, and compare write with a crossing retire.

// File: rtl/rct_pkg.sv
package rct_pkg;
    typedef enum logic [1:0] {
        SEL_CNT_LO = 2'd0,
        SEL_CNT_HI = 2'd1,
        SEL_CMP    = 2'd2,
        SEL_NONE   = 2'd3
    } csr_sel_e;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_FIRED = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/rct_counter.sv
module rct_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             wr_full_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        count_d = count_q;
        if (wr_full_i) begin
            count_d = wdata_i;
        end else if (wr_hi_i) begin
            count_d = {wdata_i[HALF_W-1:0], count_q[HALF_W-1:0]};
        end else if (retire_i) begin
            count_d = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !wr_full_i && !wr_hi_i) |=> (count_o == $past(count_o) + 1'b1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_i && !wr_full_i && !wr_hi_i) |=> $stable(count_o));

    // R6
    full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full_i |=> (count_o == $past(wdata_i)));

    // R5
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !wr_full_i) |=> (count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0])));
endmodule

// File: rtl/rct_compare.sv
module rct_compare
    import rct_pkg::*;
#(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [CMP_W-1:0] cnt_lo_i,
    input  logic             cmp_we_i,
    input  logic [CMP_W-1:0] wdata_i,
    output logic [CMP_W-1:0] cmp_o,
    output logic             pend_o
);
    localparam int EXT_W = CMP_W + 1;

    tmr_state_e       state_q, state_d;
    logic [CMP_W-1:0] cmp_q;
    logic [EXT_W-1:0] lo_ext, lo_next_ext, cmp_ext;
    logic             crossing;

    assign lo_ext      = {1'b0, cnt_lo_i};
    assign lo_next_ext = lo_ext + {{CMP_W{1'b0}}, 1'b1};
    assign cmp_ext     = {1'b0, cmp_q};
    assign crossing    = adv_i && (lo_ext <= cmp_ext) && (lo_next_ext >= cmp_ext);

    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (cmp_we_i) cmp_q <= wdata_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (!cmp_we_i && crossing) state_d = ST_FIRED;
            ST_FIRED: if (cmp_we_i)              state_d = ST_ARMED;
            default:                             state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = 1'b0;
        unique case (state_q)
            ST_ARMED: pend_o = 1'b0;
            ST_FIRED: pend_o = 1'b1;
            default:  pend_o = 1'b0;
        endcase
    end

    assign cmp_o = cmp_q;

    // R9
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_i |=> !pend_o);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !cmp_we_i) |=> pend_o);

    // R7
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(adv_i) && !$past(cmp_we_i)));

    // R9
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_i |=> (cmp_o == $past(wdata_i)));
endmodule

// File: rtl/rct_csr_port.sv
module rct_csr_port
    import rct_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                  we_i,
    input  logic [1:0]            sel_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic [CNT_W/2-1:0]    cmp_i,
    output logic                  wr_full_o,
    output logic                  wr_hi_o,
    output logic                  cmp_we_o,
    output logic [CNT_W-1:0]      rdata_o
);
    localparam int HALF_W = CNT_W / 2;

    csr_sel_e sel;
    assign sel = csr_sel_e'(sel_i);

    always_comb begin
        wr_full_o = 1'b0;
        wr_hi_o   = 1'b0;
        cmp_we_o  = 1'b0;
        rdata_o   = '0;
        unique case (sel)
            SEL_CNT_LO: begin
                wr_full_o = we_i;
                rdata_o   = {{HALF_W{1'b0}}, count_i[HALF_W-1:0]};
            end
            SEL_CNT_HI: begin
                wr_hi_o = we_i;
                rdata_o = {{HALF_W{1'b0}}, count_i[CNT_W-1:HALF_W]};
            end
            SEL_CMP: begin
                cmp_we_o = we_i;
                rdata_o  = {{HALF_W{1'b0}}, cmp_i};
            end
            SEL_NONE: rdata_o = '0;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/retire_cmp_timer.sv
module retire_cmp_timer #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             csr_we_i,
    input  logic [1:0]       csr_sel_i,
    input  logic [CNT_W-1:0] csr_wdata_i,
    output logic [CNT_W-1:0] csr_rdata_o,
    output logic             timer_pend_o
);
    localparam int HALF_W = CNT_W / 2;

    logic              wr_full, wr_hi, cmp_we, adv;
    logic [CNT_W-1:0]  count;
    logic [HALF_W-1:0] cmp_val;

    rct_csr_port #(.CNT_W(CNT_W)) u_port (
        .we_i      (csr_we_i),
        .sel_i     (csr_sel_i),
        .count_i   (count),
        .cmp_i     (cmp_val),
        .wr_full_o (wr_full),
        .wr_hi_o   (wr_hi),
        .cmp_we_o  (cmp_we),
        .rdata_o   (csr_rdata_o)
    );

    rct_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .wr_full_i (wr_full),
        .wr_hi_i   (wr_hi),
        .wdata_i   (csr_wdata_i),
        .count_o   (count)
    );

    assign adv = retire_i && !wr_full && !wr_hi;

    rct_compare #(.CMP_W(HALF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .cnt_lo_i (count[HALF_W-1:0]),
        .cmp_we_i (cmp_we),
        .wdata_i  (csr_wdata_i[HALF_W-1:0]),
        .cmp_o    (cmp_val),
        .pend_o   (timer_pend_o)
    );

    // R11
    hi_wr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we_i && csr_sel_i == 2'd1) |=> (timer_pend_o == $past(timer_pend_o)));
endmodule

// File: tb/retire_cmp_timer_tb.sv
module retire_cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        retire;
    logic        we;
    logic [1:0]  sel;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic        pend;
    int          n_checks = 0;
    int          n_errors = 0;

    always #5 clk = ~clk;

    retire_cmp_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_i     (retire),
        .csr_we_i     (we),
        .csr_sel_i    (sel),
        .csr_wdata_i  (wdata),
        .csr_rdata_o  (rdata),
        .timer_pend_o (pend)
    );

    typedef struct packed {
        logic        w;
        logic [1:0]  s;
        logic [63:0] d;
        logic        r;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        p;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 2'd2, 64'd10,                  1'b0, 32'd0,          32'd0, 1'b0},
        '{1'b1, 2'd0, 64'd8,                   1'b0, 32'd8,          32'd0, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd9,          32'd0, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd10,         32'd0, 1'b1},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd11,         32'd0, 1'b1},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd12,         32'd0, 1'b1},
        '{1'b1, 2'd2, 64'd10,                  1'b0, 32'd12,         32'd0, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd13,         32'd0, 1'b0},
        '{1'b1, 2'd1, 64'd5,                   1'b1, 32'd13,         32'd5, 1'b0},
        '{1'b1, 2'd0, 64'h0000_0002_FFFF_FFFE, 1'b1, 32'hFFFF_FFFE,  32'd2, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'hFFFF_FFFF,  32'd2, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd0,          32'd3, 1'b0},
        '{1'b1, 2'd2, 64'd1,                   1'b0, 32'd0,          32'd3, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd1,          32'd3, 1'b1},
        '{1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 32'd1,          32'd3, 1'b1},
        '{1'b1, 2'd2, 64'd1,                   1'b1, 32'd2,          32'd3, 1'b0},
        '{1'b1, 2'd2, 64'h0000_0000_FFFF_FFFF, 1'b0, 32'd2,          32'd3, 1'b0},
        '{1'b1, 2'd0, 64'h0000_0000_FFFF_FFFF, 1'b0, 32'hFFFF_FFFF,  32'd0, 1'b0},
        '{1'b0, 2'd0, 64'd0,                   1'b1, 32'd0,          32'd1, 1'b1},
        '{1'b1, 2'd1, 64'd7,                   1'b0, 32'd0,          32'd7, 1'b1},
        '{1'b0, 2'd0, 64'd0,                   1'b0, 32'd0,          32'd7, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [63:0] v);
        sel = s;
        #1;
        v = rdata;
    endtask

    task automatic idle_inputs();
        we = 1'b0; retire = 1'b0; sel = 2'd0; wdata = '0;
    endtask

    task automatic check_state(input string req, input logic [31:0] lo,
                               input logic [31:0] hi, input logic p);
        logic [63:0] v;
        rd(2'd0, v); check({req, " count low"},  v, {32'd0, lo});
        rd(2'd1, v); check({req, " count high"}, v, {32'd0, hi});
        check({req, " pending"}, {63'd0, pend}, {63'd0, p});
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] v;
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_state("R1", 32'd0, 32'd0, 1'b0);
        rd(2'd2, v); check("R1 compare", v, 64'd0);

        // vector walk: R2 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            we = VEC[i].w; sel = VEC[i].s; wdata = VEC[i].d; retire = VEC[i].r;
            @(posedge clk);
            #2;
            idle_inputs();
            check_state($sformatf("vec%0d R2-path", i), VEC[i].lo, VEC[i].hi, VEC[i].p);
        end

        // R3 read mux and zero upper bits
        rd(2'd2, v); check("R3 compare read", v, 64'h0000_0000_FFFF_FFFF);
        rd(2'd1, v); check("R3 high read", v, 64'd7);
        // R12 unused selector reads zero
        rd(2'd3, v); check("R12 unused read", v, 64'd0);

        // R3 lower read hides upper half
        @(negedge clk);
        we = 1'b1; sel = 2'd0; wdata = 64'h1234_5678_9ABC_DEF0;
        @(posedge clk); #2; idle_inputs();
        rd(2'd0, v); check("R3 low read", v, 64'h0000_0000_9ABC_DEF0);
        rd(2'd1, v); check("R4 full write high", v, 64'h0000_0000_1234_5678);

        // R1 reset mid-run, then R7 with compare 0 on first retire
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
        check_state("R1 rerun", 32'd0, 32'd0, 1'b0);
        @(negedge clk); retire = 1'b1;
        @(posedge clk); #2; idle_inputs();
        check_state("R7 cmp0", 32'd1, 32'd0, 1'b1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule